// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the controller side of a three-wire read link to a serial delta-sigma converter. It pulls chip select low and watches the data line, which the converter holds high while a conversion runs and drops low once a result is ready. When it sees that low level it produces 32 serial clock pulses and samples one data bit on each rising edge. It then splits the captured word into a dummy bit, a sign bit, a 24-bit magnitude field and five bits below the LSB.

The decoded result is offered on a valid/ready output. It is a signed 25-bit value with range flags and a framing-error flag. While a result waits to be accepted, chip select stays high and no new read starts. An abort input raises chip select at once, during polling or shifting. The converter treats this as a cancelled read and starts a fresh conversion. A poll timer pulses an error output when a conversion takes too long.

The controller is a four-state machine. IDLE holds chip select high for one cycle and always moves to POLL. POLL holds chip select low. It moves to SHIFT when the data line reads low, or to IDLE on abort. SHIFT runs the serial clock. It moves to HOLD after the falling edge that follows the 32nd rising edge, or to IDLE on abort. HOLD presents the result and moves to IDLE when it is accepted.

Top module: `sdadc_frame_reader`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, and neither the valid output nor the timeout output is asserted.
- R2: In POLL, chip select is low and the serial clock stays low for as long as the data line reads high. Clocking starts only after the data line has been seen low.
- R3: The serial clock period is DIV system cycles, and each high phase lasts DIV/2 cycles. The clock is low whenever chip select is high. A completed read has exactly 32 rising edges, and data is sampled on each one, first bit first.
- R4: Number the captured bits 31 (first) down to 0 (last). The result output is the 25-bit two's complement value {NOT bit 29, bits 28..5}.
- R5: The sub-LSB output equals captured bits 4..0.
- R6: The over-range flag is set when bits 29 and 28 are both 1. The under-range flag is set when both are 0. Otherwise neither flag is set.
- R7: The framing-error flag equals captured bit 30, which a healthy converter always sends as 0.
- R8: The valid output rises on the same cycle the serial clock falls after its 32nd rising edge. It then stays high, with every result field unchanged and chip select high, until ready is sampled high.
- R9: After a result is accepted, chip select stays high for exactly one cycle, and polling then resumes.
- R10: An abort sampled in POLL or SHIFT raises chip select and lowers the serial clock on the next cycle. No result is produced from that read.
- R11: Abort takes priority when it falls in the same cycle as the final falling clock edge of a read, or in the same cycle as the first low level on the data line during POLL.
- R12: When the data line stays high for TIMEOUT consecutive POLL cycles, the timeout output pulses for one cycle, on the TIMEOUT-th such cycle. The timer then restarts and polling continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Cancel the current read and restart conversion |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 25 | Signed result, two's complement |
| res_sub_o | output | 5 | Bits below the result LSB |
| res_ovr_o | output | 1 | Input above positive full scale |
| res_udr_o | output | 1 | Input below negative full scale |
| res_frame_err_o | output | 1 | Dummy bit read as 1 |
| timeout_o | output | 1 | Conversion-done wait exceeded TIMEOUT cycles |

## Verification
Abort can collide with two of the block's own events. The first is the completion of a read, at the cycle of the last falling clock edge. The bench counts serial clock rising edges at the pins and waits until the 32nd edge has been seen. It then steps through the remaining high phase and raises abort exactly on that final high cycle. The second is the converter's done signal: in POLL, the bench drops the data line low and raises abort in the same cycle. In both cases it judges that chip select rises on the next cycle, that no valid ever appears, and that no clock pulses follow. A normal read is then run to confirm that the block recovers cleanly.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;
    localparam int RES_W   = 24;
    localparam int SUB_W   = 5;
    localparam int FRAME_W = RES_W + SUB_W + 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_POLL,
        S_SHIFT,
        S_HOLD
    } rd_state_t;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic halt,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int LO = DIV - DIV / 2;

    logic [CW-1:0] cnt_q, cnt_nxt;

    assign cnt_nxt   = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    assign rise_tick = run && (cnt_q == CW'(LO - 1));
    assign fall_tick = run && (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || halt) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            sclk  <= (cnt_nxt >= CW'(LO));
        end
    end

    // R3
    tick_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-2:0] frame,
    output logic         full
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] bit_cnt;

    assign full = (bit_cnt == CNT_W'(W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            frame   <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (shift_en && !full) begin
            bit_cnt <= bit_cnt + 1'b1;
            frame   <= {frame[W-3:0], din};
        end
    end

    // R3
    no_overshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && full));
endmodule

// File: rtl/frame_fields.sv
module frame_fields
    import sdrd_pkg::*;
(
    input  logic [FRAME_W-2:0] frame,
    output logic [RES_W:0]     data,
    output logic [SUB_W-1:0]   sub,
    output logic               ovr,
    output logic               udr,
    output logic               dmy_err
);
    logic sign_bit, top_bit;

    always_comb begin
        dmy_err  = frame[FRAME_W-2];
        sign_bit = frame[RES_W + SUB_W];
        top_bit  = frame[RES_W + SUB_W - 1];
        data     = {~sign_bit, frame[SUB_W +: RES_W]};
        sub      = frame[SUB_W-1:0];
        ovr      = sign_bit && top_bit;
        udr      = !sign_bit && !top_bit;
    end
endmodule

// File: rtl/sdadc_frame_reader.sv
module sdadc_frame_reader
    import sdrd_pkg::*;
#(
    parameter int DIV     = 8,
    parameter int TIMEOUT = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    input  logic             sdi_i,
    output logic             res_valid_o,
    input  logic             res_ready_i,
    output logic [RES_W:0]   res_data_o,
    output logic [SUB_W-1:0] res_sub_o,
    output logic             res_ovr_o,
    output logic             res_udr_o,
    output logic             res_frame_err_o,
    output logic             timeout_o
);
    localparam int TO_W = $clog2(TIMEOUT + 1);

    rd_state_t          state_q, state_d;
    logic [TO_W-1:0]    to_cnt_q;
    logic               rise_tick, fall_tick, frame_full, in_shift, poll_expire;
    logic [FRAME_W-2:0] frame;

    assign in_shift    = (state_q == S_SHIFT);
    assign poll_expire = (state_q == S_POLL) && sdi_i && (to_cnt_q == TO_W'(TIMEOUT - 1));

    sclk_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(in_shift), .halt(abort_i),
        .sclk(sclk_o), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    frame_capture #(.W(FRAME_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(!in_shift), .shift_en(rise_tick),
        .din(sdi_i), .frame(frame), .full(frame_full)
    );

    frame_fields u_dec (
        .frame(frame), .data(res_data_o), .sub(res_sub_o),
        .ovr(res_ovr_o), .udr(res_udr_o), .dmy_err(res_frame_err_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = S_POLL;
            S_POLL:  if (abort_i)                     state_d = S_IDLE;
                     else if (!sdi_i)                 state_d = S_SHIFT;
            S_SHIFT: if (abort_i)                     state_d = S_IDLE;
                     else if (frame_full && fall_tick) state_d = S_HOLD;
            S_HOLD:  if (res_ready_i)                 state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            to_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != S_POLL || poll_expire) to_cnt_q <= '0;
            else if (sdi_i)                       to_cnt_q <= to_cnt_q + 1'b1;
        end
    end

    always_comb begin
        cs_n_o      = !((state_q == S_POLL) || (state_q == S_SHIFT));
        res_valid_o = (state_q == S_HOLD);
        timeout_o   = poll_expire;
    end

    // R2
    poll_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL) |-> !sclk_o);
    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_sub_o)));
    // R8
    hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> cs_n_o);
    // R10
    abort_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o));
    // R11
    abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !cs_n_o) |=> !res_valid_o);
    // R12
    timeout_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!cs_n_o && sdi_i));
endmodule

// File: tb/sdadc_frame_reader_bench.sv
`timescale 1ns/1ps
module sdadc_frame_reader_bench;
    localparam int DIV = 4;
    localparam int TMO = 20;
    localparam int NV  = 8;

    // entry: {frame[31:0], data[24:0], sub[4:0], ovr, udr, ferr}
    localparam logic [64:0] VEC [NV] = '{
        {{1'b0, 1'b0, 1'b1, 24'h000123, 5'h05}, 25'h0000123, 5'h05, 1'b0, 1'b0, 1'b0},
        {{1'b0, 1'b0, 1'b0, 24'hFFFFFF, 5'h1F}, 25'h1FFFFFF, 5'h1F, 1'b0, 1'b0, 1'b0},
        {{1'b0, 1'b0, 1'b1, 24'h800000, 5'h00}, 25'h0800000, 5'h00, 1'b1, 1'b0, 1'b0},
        {{1'b0, 1'b0, 1'b0, 24'h000000, 5'h0C}, 25'h1000000, 5'h0C, 1'b0, 1'b1, 1'b0},
        {{1'b0, 1'b0, 1'b1, 24'h7FFFFF, 5'h10}, 25'h07FFFFF, 5'h10, 1'b0, 1'b0, 1'b0},
        {{1'b0, 1'b0, 1'b0, 24'h800000, 5'h01}, 25'h1800000, 5'h01, 1'b0, 1'b0, 1'b0},
        {{1'b0, 1'b1, 1'b1, 24'h0ABCDE, 5'h0A}, 25'h00ABCDE, 5'h0A, 1'b0, 1'b0, 1'b1},
        {{1'b0, 1'b0, 1'b1, 24'h555555, 5'h15}, 25'h0555555, 5'h15, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, abort_i = 1'b0, res_ready_i = 1'b0;
    logic cs_n_o, sclk_o, sdi_i, res_valid_o, res_ovr_o, res_udr_o, res_frame_err_o, timeout_o;
    logic [24:0] res_data_o;
    logic [4:0]  res_sub_o;

    logic        busy = 1'b1;
    logic [31:0] pframe = '0;
    int idx = 31, rises = 0, gap = 0, hi_len = 0, snap_rises = 0;
    bit shape_bad = 0, snap_bad = 0, mon_cs = 1, mon_sclk = 0;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sdadc_frame_reader #(.DIV(DIV), .TIMEOUT(TMO)) u_sdadc_frame_reader (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sdi_i(sdi_i), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
        .res_data_o(res_data_o), .res_sub_o(res_sub_o), .res_ovr_o(res_ovr_o),
        .res_udr_o(res_udr_o), .res_frame_err_o(res_frame_err_o), .timeout_o(timeout_o)
    );

    // converter model: busy holds the line high, data moves on falling sclk
    assign sdi_i = cs_n_o ? 1'b1 : (busy ? 1'b1 : ((idx >= 0) ? pframe[idx] : 1'b1));

    always @(negedge clk) begin
        if (cs_n_o) begin
            if (!mon_cs) begin snap_rises = rises; snap_bad = shape_bad; end
            rises = 0; shape_bad = 0; gap = 0; hi_len = 0; idx = 31;
        end else begin
            gap++;
            if (sclk_o && !mon_sclk) begin
                rises++;
                if (rises > 1 && gap != DIV) shape_bad = 1;
                gap = 0;
            end
            if (sclk_o) hi_len++;
            if (!sclk_o && mon_sclk) begin
                if (hi_len != DIV / 2) shape_bad = 1;
                hi_len = 0;
                idx--;
            end
        end
        mon_cs = cs_n_o; mon_sclk = sclk_o;
    end

    task automatic step;
        @(negedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cs_low;
        for (int k = 0; k < 200 && cs_n_o; k++) step;
    endtask

    task automatic run_frame(input logic [64:0] v, input int hold);
        bit early_clk;
        bit hold_ok;
        logic [24:0] d0;
        pframe = v[64:33];
        busy = 1'b1;
        wait_cs_low;
        early_clk = 0;
        for (int k = 0; k < 6; k++) begin if (sclk_o) early_clk = 1; step; end
        chk("R2 no clock while busy", {31'd0, early_clk}, 32'd0);
        busy = 1'b0;
        for (int k = 0; k < 1000 && !res_valid_o; k++) step;
        busy = 1'b1;
        chk("R8 valid reached", {31'd0, res_valid_o}, 32'd1);
        chk("R3 rising edge count", snap_rises, 32'd32);
        chk("R3 clock period and high width", {31'd0, snap_bad}, 32'd0);
        chk("R4 result", {7'd0, res_data_o}, {7'd0, v[32:8]});
        chk("R5 sub bits", {27'd0, res_sub_o}, {27'd0, v[7:3]});
        chk("R6 range flags", {30'd0, res_ovr_o, res_udr_o}, {30'd0, v[2:1]});
        chk("R7 frame error", {31'd0, res_frame_err_o}, {31'd0, v[0]});
        d0 = res_data_o;
        hold_ok = 1;
        for (int k = 0; k < hold; k++) begin
            step;
            if (!res_valid_o || !cs_n_o || sclk_o || res_data_o !== d0) hold_ok = 0;
        end
        chk("R8 result held until ready", {31'd0, hold_ok}, 32'd1);
        res_ready_i = 1'b1;
        step;
        res_ready_i = 1'b0;
        chk("R9 valid drops after accept", {31'd0, res_valid_o}, 32'd0);
        chk("R9 one idle cycle", {31'd0, cs_n_o}, 32'd1);
        step;
        chk("R9 polling resumes", {31'd0, cs_n_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit quiet;
        int pulses, first_k;
        repeat (3) step;
        chk("R1 cs_n in reset", {31'd0, cs_n_o}, 32'd1);
        chk("R1 sclk in reset", {31'd0, sclk_o}, 32'd0);
        chk("R1 valid/timeout in reset", {30'd0, res_valid_o, timeout_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_frame(VEC[i], 1 + (i * 3) % 7);

        // R10: abort in the middle of shifting
        pframe = VEC[0][64:33];
        wait_cs_low;
        busy = 1'b0;
        for (int k = 0; k < 500 && rises < 10; k++) step;
        abort_i = 1'b1; busy = 1'b1;
        step;
        abort_i = 1'b0;
        chk("R10 cs_n high after abort", {30'd0, cs_n_o, sclk_o}, 32'd2);
        quiet = 1;
        for (int k = 0; k < 15; k++) begin step; if (res_valid_o || sclk_o) quiet = 0; end
        chk("R10 no result after abort", {31'd0, quiet}, 32'd1);
        run_frame(VEC[3], 2);

        // R11: abort on the final high cycle of a read
        pframe = VEC[4][64:33];
        wait_cs_low;
        busy = 1'b0;
        for (int k = 0; k < 1000 && rises < 32; k++) step;
        repeat (DIV / 2 - 1) step;
        abort_i = 1'b1; busy = 1'b1;
        step;
        abort_i = 1'b0;
        chk("R11 abort beats completion", {30'd0, res_valid_o, cs_n_o}, 32'd1);
        quiet = 1;
        for (int k = 0; k < 15; k++) begin step; if (res_valid_o || sclk_o) quiet = 0; end
        chk("R11 no late result", {31'd0, quiet}, 32'd1);

        // R11: abort in the cycle the data line first reads low
        pframe = VEC[5][64:33];
        wait_cs_low;
        step;
        busy = 1'b0; abort_i = 1'b1;
        step;
        abort_i = 1'b0; busy = 1'b1;
        chk("R11 abort beats done flag", {31'd0, cs_n_o}, 32'd1);
        quiet = 1;
        for (int k = 0; k < 15; k++) begin step; if (res_valid_o || sclk_o) quiet = 0; end
        chk("R11 no clock after abort in poll", {31'd0, quiet}, 32'd1);
        run_frame(VEC[5], 3);

        // R12: poll timeout pulses
        abort_i = 1'b1;
        step;
        abort_i = 1'b0;
        step;
        pulses = 0; first_k = 0;
        for (int k = 1; k <= 45; k++) begin
            if (timeout_o) begin pulses++; if (first_k == 0) first_k = k; end
            step;
        end
        chk("R12 timeout pulse count", pulses, 32'd2);
        chk("R12 first timeout cycle", first_k, TMO);
        run_frame(VEC[6], 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule